// File: doc/BRIEF.md
# Streaming 3x3 Fixed-Point Convolution Unit

This unit slides a 3x3 kernel across a stored feature map and produces one signed fixed-point result per accepted column step. The image memory feeding it is scanned line by line. Each step delivers one column of three vertically adjacent pixels: the row above the current output row, the row itself and the row below. A three-column shift register keeps six pixels from earlier steps, so each step brings in only three fresh values. Window positions that fall outside the map are forced to zero by edge logic, and no padded copy of the map is stored.

A start pulse latches a packed word of nine weights, the ReLU enable and the per-layer clamp magnitude, and clears the window and the running maximum. The nine products are summed at full width with no bias. The sum is shifted right arithmetically once by the fractional width. The result is clamped when it leaves the signed output range and then optionally passed through ReLU. A running maximum over all outputs of the map serves as the global max-pooling value. A flag marks the last output of the map.

Control is a three-state machine. `IDLE` waits for start (transition BEGIN). `SCAN` accepts columns, restarts on start (RESTART) and moves on after the final column (LASTCOL). `FLUSH` spends one cycle producing the bottom-right output with no input, then goes back to `IDLE` (DRAIN), or to `SCAN` on start.

Top module: `conv3x3_stream`

## Requirements
- R1: After reset, out_vld and out_last are low and gmax equals -2^(DW-1).
- R2: Each output equals floor((sum over k of w_k * p_k) / 2^FRAC), with no bias term. Weight k = 3*row + col (row 0 top, col 0 left) sits at bits [k*DW +: DW] of the packed weight word, and all values are two's complement.
- R3: If the shifted sum exceeds 2^(DW-1)-1, the output is the latched clamp magnitude. If it is below -2^(DW-1), the output is minus that magnitude.
- R4: With ReLU latched on, a negative result becomes 0. With ReLU off, negative results pass unchanged.
- R5: Window taps above row 0, below row MAP_H-1, left of column 0 or right of column MAP_W-1 contribute zero, whatever is presented on the column inputs for them.
- R6: A map of MAP_W*MAP_H accepted columns yields exactly MAP_W*MAP_H outputs in raster order. The output centred on (r,c) is registered two clock edges after the edge that accepts the column to its right: column c+1 of row r, or column 0 of row r+1 when c is the last column, or the FLUSH cycle for the final output.
- R7: Idle cycles in in_vld during SCAN stall the window and do not change the results.
- R8: out_last is high together with out_vld on the final output of a map, and on no other cycle.
- R9: A start edge resets gmax to -2^(DW-1). After each output, gmax is the maximum of all outputs of the map so far.
- R10: Weights, ReLU enable and clamp magnitude are sampled only on start. Changing them during a scan has no effect on that map.
- R11: in_vld while in IDLE is ignored and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a map; latches configuration and clears window and maximum |
| weights | input | 9*DW | Packed signed kernel, tap k at bits [k*DW +: DW] |
| relu_en | input | 1 | ReLU enable, latched on start |
| sat_lim | input | DW | Clamp magnitude, latched on start |
| in_vld | input | 1 | Column step valid |
| in_top | input | DW | Pixel of the row above, current column |
| in_mid | input | DW | Pixel of the current row, current column |
| in_bot | input | DW | Pixel of the row below, current column |
| out_vld | output | 1 | Result valid |
| out_data | output | DW | Signed result |
| out_last | output | 1 | Final result of the map |
| gmax | output | DW | Running maximum of results since start |

## Verification
A result is registered two edges after the edge that accepts the column completing its window. It passes through the product register and then the output register, so the first output of a map appears two edges after the second column is taken. A dedicated scenario feeds two columns, stops, and checks that out_vld is still low one edge later and high with the expected value at the second edge. All other results are collected by a monitor on the falling edge and compared in raster order against a model that applies the same zero-padding, floor shift, clamp and ReLU rules. gmax is sampled after the drain cycles, once the final output has been registered.

// File: rtl/conv3_pkg.sv
package conv3_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SCAN  = 2'd1,
        S_FLUSH = 2'd2
    } scan_state_e;

    localparam int TAPS = 9;

endpackage

// File: rtl/conv3_window.sv
module conv3_window #(
    parameter int DW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift,
    input  logic [3*DW-1:0]   col_in,
    input  logic              cut_top,
    input  logic              cut_bot,
    input  logic              cut_lft,
    input  logic              cut_rgt,
    output logic [9*DW-1:0]   taps
);

    for (genvar r = 0; r < 3; r++) begin : g_row
        logic [DW-1:0] lf_q, md_q, rt_q;
        logic          row_cut;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lf_q <= '0;
                md_q <= '0;
                rt_q <= '0;
            end else if (clr) begin
                lf_q <= '0;
                md_q <= '0;
                rt_q <= '0;
            end else if (shift) begin
                lf_q <= md_q;
                md_q <= rt_q;
                rt_q <= col_in[r*DW +: DW];
            end
        end

        if (r == 0) begin : g_top
            assign row_cut = cut_top;
        end else if (r == 2) begin : g_bot
            assign row_cut = cut_bot;
        end else begin : g_mid
            assign row_cut = 1'b0;
        end

        assign taps[(3*r+0)*DW +: DW] = (row_cut || cut_lft) ? '0 : lf_q;
        assign taps[(3*r+1)*DW +: DW] = row_cut              ? '0 : md_q;
        assign taps[(3*r+2)*DW +: DW] = (row_cut || cut_rgt) ? '0 : rt_q;
    end

endmodule

// File: rtl/conv3_mac.sv
module conv3_mac
    import conv3_pkg::*;
#(
    parameter int DW = 12,
    parameter int SW = 2*DW + 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TAPS*DW-1:0]    taps,
    input  logic [TAPS*DW-1:0]    wgts,
    output logic signed [SW-1:0]  sum
);

    localparam int PW = 2*DW;

    logic signed [PW-1:0] prod_q [TAPS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) prod_q[k] <= '0;
        end else begin
            for (int k = 0; k < TAPS; k++)
                prod_q[k] <= $signed(taps[k*DW +: DW]) * $signed(wgts[k*DW +: DW]);
        end
    end

    // full-width accumulation of nine products, eight adders
    always_comb begin
        sum = '0;
        for (int k = 0; k < TAPS; k++)
            sum = sum + $signed({{(SW-PW){prod_q[k][PW-1]}}, prod_q[k]});
    end

endmodule

// File: rtl/conv3_post.sv
module conv3_post #(
    parameter int DW   = 12,
    parameter int SW   = 2*DW + 4,
    parameter int FRAC = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  vld_in,
    input  logic                  last_in,
    input  logic signed [SW-1:0]  sum,
    input  logic [DW-1:0]         lim,
    input  logic                  relu,
    output logic                  out_vld,
    output logic                  out_last,
    output logic signed [DW-1:0]  out_data,
    output logic signed [DW-1:0]  gmax
);

    localparam logic signed [SW-1:0] HI   = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [SW-1:0] LO   = ~HI;
    localparam logic signed [DW-1:0] DMIN = {1'b1, {(DW-1){1'b0}}};

    logic signed [SW-1:0] rnd;
    logic signed [DW-1:0] lim_s, sat, res;

    assign rnd   = sum >>> FRAC;
    assign lim_s = $signed(lim);

    always_comb begin
        if (rnd > HI)      sat = lim_s;
        else if (rnd < LO) sat = -lim_s;
        else               sat = rnd[DW-1:0];
        res = (relu && sat[DW-1]) ? '0 : sat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_last <= 1'b0;
            out_data <= '0;
            gmax     <= DMIN;
        end else if (clr) begin
            out_vld  <= 1'b0;
            out_last <= 1'b0;
            gmax     <= DMIN;
        end else begin
            out_vld  <= vld_in;
            out_last <= vld_in && last_in;
            if (vld_in) begin
                out_data <= res;
                if (res > gmax) gmax <= res;
            end
        end
    end

    p_gmax_covers_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (gmax >= out_data));

    p_relu_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && relu) |-> !out_data[DW-1]);

endmodule

// File: rtl/conv3x3_stream.sv
module conv3x3_stream
    import conv3_pkg::*;
#(
    parameter int DW    = 12,
    parameter int FRAC  = 11,
    parameter int MAP_W = 28,
    parameter int MAP_H = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [9*DW-1:0]     weights,
    input  logic                relu_en,
    input  logic [DW-1:0]       sat_lim,
    input  logic                in_vld,
    input  logic [DW-1:0]       in_top,
    input  logic [DW-1:0]       in_mid,
    input  logic [DW-1:0]       in_bot,
    output logic                out_vld,
    output logic [DW-1:0]       out_data,
    output logic                out_last,
    output logic [DW-1:0]       gmax
);

    localparam int SW = 2*DW + 4;
    localparam int RW = (MAP_H > 1) ? $clog2(MAP_H) : 1;
    localparam int CW = (MAP_W > 1) ? $clog2(MAP_W) : 1;
    localparam logic [RW-1:0] ROW_END = RW'(MAP_H - 1);
    localparam logic [CW-1:0] COL_END = CW'(MAP_W - 1);

    scan_state_e state_q, state_d;
    logic accept, flush, shift, at_end;

    logic [RW-1:0] ir_q, cen_row_q;
    logic [CW-1:0] ic_q, cen_col_q;
    logic          cen_vld_q, cen_last_q, a_vld_q, a_last_q;

    logic [9*DW-1:0] wgt_q;
    logic            relu_q;
    logic [DW-1:0]   lim_q;

    logic [3*DW-1:0] col_in;
    logic [9*DW-1:0] taps;
    logic signed [SW-1:0] sum;
    logic signed [DW-1:0] res_data, res_max;

    assign at_end = (ir_q == ROW_END) && (ic_q == COL_END);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_SCAN;                  // BEGIN
            S_SCAN:  if (start) state_d = S_SCAN;                  // RESTART
                     else if (in_vld && at_end) state_d = S_FLUSH; // LASTCOL
            S_FLUSH: state_d = start ? S_SCAN : S_IDLE;            // DRAIN
            default: state_d = S_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        accept = 1'b0;
        flush  = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_SCAN:  accept = in_vld && !start;
            S_FLUSH: flush  = !start;
            default: ;
        endcase
        shift = accept || flush;
    end

    // scan position of the next column
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q <= '0;
            ic_q <= '0;
        end else if (start) begin
            ir_q <= '0;
            ic_q <= '0;
        end else if (accept) begin
            if (ic_q == COL_END) begin
                ic_q <= '0;
                ir_q <= at_end ? '0 : ir_q + 1'b1;
            end else begin
                ic_q <= ic_q + 1'b1;
            end
        end
    end

    // per-map configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wgt_q  <= '0;
            relu_q <= 1'b0;
            lim_q  <= '0;
        end else if (start) begin
            wgt_q  <= weights;
            relu_q <= relu_en;
            lim_q  <= sat_lim;
        end
    end

    // centre of the window now held in the shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cen_vld_q  <= 1'b0;
            cen_last_q <= 1'b0;
            cen_row_q  <= '0;
            cen_col_q  <= '0;
        end else if (start) begin
            cen_vld_q  <= 1'b0;
            cen_last_q <= 1'b0;
        end else if (accept) begin
            cen_vld_q  <= (ir_q != '0) || (ic_q != '0);
            cen_last_q <= 1'b0;
            cen_row_q  <= (ic_q == '0) ? ir_q - 1'b1 : ir_q;
            cen_col_q  <= (ic_q == '0) ? COL_END : ic_q - 1'b1;
        end else if (flush) begin
            cen_vld_q  <= 1'b1;
            cen_last_q <= 1'b1;
            cen_row_q  <= ROW_END;
            cen_col_q  <= COL_END;
        end else begin
            cen_vld_q  <= 1'b0;
            cen_last_q <= 1'b0;
        end
    end

    // valid alongside the product register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_vld_q  <= 1'b0;
            a_last_q <= 1'b0;
        end else begin
            a_vld_q  <= cen_vld_q && !start;
            a_last_q <= cen_last_q && !start;
        end
    end

    assign col_in = flush ? '0 : {in_bot, in_mid, in_top};

    conv3_window #(.DW(DW)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start),
        .shift   (shift),
        .col_in  (col_in),
        .cut_top (cen_row_q == '0),
        .cut_bot (cen_row_q == ROW_END),
        .cut_lft (cen_col_q == '0),
        .cut_rgt (cen_col_q == COL_END),
        .taps    (taps)
    );

    conv3_mac #(.DW(DW), .SW(SW)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  (taps),
        .wgts  (wgt_q),
        .sum   (sum)
    );

    conv3_post #(.DW(DW), .SW(SW), .FRAC(FRAC)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start),
        .vld_in   (a_vld_q),
        .last_in  (a_last_q),
        .sum      (sum),
        .lim      (lim_q),
        .relu     (relu_q),
        .out_vld  (out_vld),
        .out_last (out_last),
        .out_data (res_data),
        .gmax     (res_max)
    );

    assign out_data = res_data;
    assign gmax     = res_max;

    p_last_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_vld);

    p_last_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_last);

    p_flush_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FLUSH && !start) |=> (state_q == S_IDLE));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !start) |=> (!cen_vld_q && $stable(ir_q) && $stable(ic_q)));

    p_start_scan_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == S_SCAN && ir_q == '0 && ic_q == '0));

endmodule

// File: tb/conv3x3_stream_bench.sv
module conv3x3_stream_bench;

    localparam int DW   = 12;
    localparam int FRAC = 11;
    localparam int W    = 28;
    localparam int H    = 28;
    localparam int N    = W * H;
    localparam int DMIN = -(1 << (DW-1));
    localparam int DMAX = (1 << (DW-1)) - 1;
    localparam int GARB = 1445;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [9*DW-1:0] weights = '0;
    logic relu_en = 1'b0;
    logic [DW-1:0] sat_lim = '0;
    logic in_vld = 1'b0;
    logic [DW-1:0] in_top = '0, in_mid = '0, in_bot = '0;
    logic out_vld, out_last;
    logic [DW-1:0] out_data, gmax;

    always #2 clk = ~clk;

    conv3x3_stream u_conv3x3_stream (
        .clk(clk), .rst_n(rst_n), .start(start), .weights(weights),
        .relu_en(relu_en), .sat_lim(sat_lim), .in_vld(in_vld),
        .in_top(in_top), .in_mid(in_mid), .in_bot(in_bot),
        .out_vld(out_vld), .out_data(out_data), .out_last(out_last), .gmax(gmax)
    );

    int n_chk = 0, n_err = 0;
    int seed = 7;
    int img [H][W];
    int wts [9];
    int got_data [N];
    bit got_last [N];
    int got_cnt = 0;
    bit finished = 0;

    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (got_cnt < N) begin
                got_data[got_cnt] = $signed(out_data);
                got_last[got_cnt] = out_last;
            end
            got_cnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int rnd(input int amp);
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 16) & 32767) % (2*amp + 1) - amp;
    endfunction

    task automatic fill(input int pamp, input int wamp);
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) img[r][c] = rnd(pamp);
        for (int k = 0; k < 9; k++) wts[k] = rnd(wamp);
    endtask

    function automatic logic [9*DW-1:0] pack();
        logic [9*DW-1:0] p;
        for (int k = 0; k < 9; k++) p[k*DW +: DW] = wts[k][DW-1:0];
        return p;
    endfunction

    function automatic int model(input int r, input int c, input int relu, input int lim);
        longint s = 0;
        longint sh;
        int v;
        for (int kr = 0; kr < 3; kr++)
            for (int kc = 0; kc < 3; kc++) begin
                int rr = r + kr - 1;
                int cc = c + kc - 1;
                if (rr >= 0 && rr < H && cc >= 0 && cc < W)
                    s += longint'(wts[kr*3+kc]) * longint'(img[rr][cc]);
            end
        sh = s >>> FRAC;
        if (sh > DMAX)      v = lim;
        else if (sh < DMIN) v = -lim;
        else                v = int'(sh);
        if (relu != 0 && v < 0) v = 0;
        return v;
    endfunction

    task automatic drive_col(input int r, input int c);
        in_vld = 1'b1;
        in_top = (r > 0)     ? img[r-1][c][DW-1:0] : GARB[DW-1:0];
        in_mid = img[r][c][DW-1:0];
        in_bot = (r < H - 1) ? img[r+1][c][DW-1:0] : GARB[DW-1:0];
    endtask

    task automatic pulse_start(input int relu, input int lim);
        @(negedge clk);
        start = 1'b1; weights = pack(); relu_en = relu[0]; sat_lim = lim[DW-1:0];
        @(negedge clk);
        start = 1'b0;
    endtask

    // R1: state after reset
    task automatic t_reset();
        chk(out_vld == 1'b0, "R1 out_vld", int'(out_vld), 0);
        chk(out_last == 1'b0, "R1 out_last", int'(out_last), 0);
        chk($signed(gmax) == DMIN, "R1 gmax", $signed(gmax), DMIN);
    endtask

    // R11: columns offered while idle are dropped
    task automatic t_idle(input string tag);
        got_cnt = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            drive_col(1, i);
        end
        @(negedge clk);
        in_vld = 1'b0;
        repeat (6) @(negedge clk);
        chk(got_cnt == 0, tag, got_cnt, 0);
    endtask

    // R6: first result two edges after the second column is accepted
    task automatic t_latency();
        int e = model(0, 0, 0, DMAX);
        pulse_start(0, DMAX);
        drive_col(0, 0);
        @(negedge clk);
        drive_col(0, 1);
        @(negedge clk);
        in_vld = 1'b0;
        chk(out_vld == 1'b0, "R6 no result at accept edge", int'(out_vld), 0);
        @(negedge clk);
        chk(out_vld == 1'b0, "R6 no result one edge later", int'(out_vld), 0);
        @(negedge clk);
        chk(out_vld == 1'b1, "R6 result two edges later", int'(out_vld), 1);
        chk($signed(out_data) == e, "R6 R2 first value", $signed(out_data), e);
        @(negedge clk);
        chk(out_vld == 1'b0, "R6 single pulse", int'(out_vld), 0);
    endtask

    task automatic run_map(input int relu, input int lim, input bit gaps,
                           input bit perturb, input string tag);
        int mx = DMIN;
        int nlast = 0;
        int lastpos = -1;
        int bad = 0;
        got_cnt = 0;
        pulse_start(relu, lim);
        chk($signed(gmax) == DMIN, "R9 gmax cleared by start", $signed(gmax), DMIN);
        if (perturb) begin
            weights = ~pack(); relu_en = ~relu_en; sat_lim = 12'd5;
        end
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) begin
                if (gaps && ((r*W + c) % 5 == 3)) begin
                    in_vld = 1'b0;
                    @(negedge clk);
                end
                drive_col(r, c);
                @(negedge clk);
            end
        in_vld = 1'b0;
        repeat (6) @(negedge clk);
        chk(got_cnt == N, "R6 output count", got_cnt, N);
        for (int i = 0; i < N && i < got_cnt; i++) begin
            int e = model(i / W, i % W, relu, lim);
            if (e > mx) mx = e;
            if (got_last[i]) begin nlast++; lastpos = i; end
            if (got_data[i] != e) begin
                bad++;
                if (bad <= 4) chk(1'b0, tag, got_data[i], e);
            end
        end
        chk(bad == 0, {tag, " mismatch count"}, bad, 0);
        chk(nlast == 1, "R8 last count", nlast, 1);
        chk(lastpos == N - 1, "R8 last position", lastpos, N - 1);
        chk($signed(gmax) == mx, "R9 gmax", $signed(gmax), mx);
        weights = pack(); relu_en = relu[0]; sat_lim = lim[DW-1:0];
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle("R11 idle after reset");
        fill(600, 400);
        t_latency();
        run_map(0, DMAX, 1'b0, 1'b0, "R2 R5 plain map");
        t_idle("R11 idle after map");
        fill(900, 500);
        run_map(1, DMAX, 1'b1, 1'b0, "R4 R7 relu with gaps");
        fill(2000, 2000);
        run_map(0, 1000, 1'b0, 1'b0, "R3 clamp");
        fill(1500, 1500);
        run_map(1, 700, 1'b1, 1'b1, "R10 config held");
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule